// File: doc/BRIEF.md
# Sequence-Programmed Fractional Clock Divider

This block divides a fast input clock by a ratio that may be fractional. For each output period it counts either N or N+1 input clocks. A short stored select pattern decides which count applies, and that pattern replays over a programmable number of output periods. The average ratio is therefore N plus (number of set pattern bits) divided by (length field + 1). The same block can serve either as a crystal prescaler ahead of a phase-locked loop or as the loop's feedback divider.

Configuration enters through a simple load port into staging registers. The working copy takes the staged values only when a full replay cycle completes, or on reset. A sequence is therefore never run with part old and part new settings. The output is a strobe one input clock wide, asserted in the final input clock of each divided period.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low, `div_strobe` is 0. After reset the working configuration is divisor 8, length field 0, pattern 00h. The first divided period starts in the first clock after reset is released and uses the first pattern position.
- R2: Each divided period lasts exactly N or N+1 input clocks. `div_strobe` is high only in the last clock of the period.
- R3: A select bit of 1 makes that period last N+1 clocks. A select bit of 0 makes it last N clocks.
- R4: For length field L, the pattern bits are used in the order L, L-1, ..., 0. The order then wraps back to bit L. So the replay cycle holds exactly L+1 periods.
- R5: When the length field is 0, the pattern is ignored and every period lasts exactly N clocks.
- R6: A divisor field of 0 or 1 is treated as 2.
- R7: A value written with `cfg_we` takes effect only at the start of the first replay cycle that begins after the clock in which it was captured. A write in the same clock as a cycle end waits one more full cycle.
- R8: `div_strobe` is never high in two consecutive clocks.
- R9: Divisor 19, length field 4 and pattern 01h give periods of 19, 19, 19, 19, 20 clocks, repeating. This is an average ratio of 96/5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Captures the three configuration words into staging |
| cfg_int_div | input | 7 | Integer divisor N |
| cfg_len | input | 3 | Replay length minus one (L) |
| cfg_pattern | input | 8 | Per-period select bits, 1 = N+1 |
| div_strobe | output | 1 | One-clock pulse closing each divided period |

## Verification
The bench targets four corners. The first is the wrap from bit 0 back to bit L, where an off-by-one would give a cycle of L or L+2 periods. The second is the length-0 case with an all-ones pattern, where a design that reads the pattern anyway would stretch every period to N+1. The third is divisor values 0 and 1, where a design without the clamp would stall or emit a continuous strobe. The fourth is writes placed mid-cycle and back to back; a design that applies them at once would show mixed-length cycles. A reset in the middle of a run checks that the sequence position restarts.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int ARITH_W = 16;

  // Divisor with the lower clamp applied.
  function automatic logic [ARITH_W-1:0] eff_div(input logic [ARITH_W-1:0] d);
    return (d < 2) ? ARITH_W'(2) : d;
  endfunction

  // Length of one divided period in input clocks.
  function automatic logic [ARITH_W-1:0] period_len(input logic [ARITH_W-1:0] d,
                                                    input logic stretch);
    return eff_div(d) + ARITH_W'(stretch);
  endfunction
endpackage

// File: rtl/fd_cfg_stage.sv
module fd_cfg_stage #(
  parameter int DIV_W   = 7,
  parameter int LEN_W   = 3,
  parameter int PAT_W   = 8,
  parameter int DEF_DIV = 8,
  parameter int DEF_LEN = 0,
  parameter int DEF_PAT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] wr_div,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [PAT_W-1:0] wr_pat,
  input  logic             cycle_end,
  output logic [DIV_W-1:0] act_div,
  output logic [LEN_W-1:0] act_len,
  output logic [PAT_W-1:0] act_pat,
  output logic [LEN_W-1:0] stg_len
);
  logic [DIV_W-1:0] stg_div;
  logic [PAT_W-1:0] stg_pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_div <= DIV_W'(DEF_DIV);
      stg_len <= LEN_W'(DEF_LEN);
      stg_pat <= PAT_W'(DEF_PAT);
    end else if (we) begin
      stg_div <= wr_div;
      stg_len <= wr_len;
      stg_pat <= wr_pat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= DIV_W'(DEF_DIV);
      act_len <= LEN_W'(DEF_LEN);
      act_pat <= PAT_W'(DEF_PAT);
    end else if (cycle_end) begin
      act_div <= stg_div;
      act_len <= stg_len;
      act_pat <= stg_pat;
    end
  end

  // R7: the working copy moves only at a replay-cycle boundary
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> ($stable(act_div) && $stable(act_len) && $stable(act_pat)));
endmodule

// File: rtl/fd_seq_ptr.sv
module fd_seq_ptr #(
  parameter int LEN_W   = 3,
  parameter int PAT_W   = 8,
  parameter int DEF_LEN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [LEN_W-1:0] act_len,
  input  logic [PAT_W-1:0] act_pat,
  input  logic [LEN_W-1:0] stg_len,
  output logic             sel,
  output logic             cycle_end
);
  logic [LEN_W-1:0] pos;
  logic             last_pos;

  assign last_pos  = (pos == '0);
  assign cycle_end = strobe && last_pos;
  assign sel       = (act_len != '0) && act_pat[pos];

  always_ff @(posedge clk) begin
    if (!rst_n)        pos <= LEN_W'(DEF_LEN);
    else if (cycle_end) pos <= stg_len;
    else if (strobe)    pos <= pos - 1'b1;
  end

  // R4: position never exceeds the working length field
  assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= act_len);
  // R4: inside a cycle the position steps down by one per period
  assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !last_pos) |=> (pos == $past(pos) - 1'b1));
  // R5: a zero length field never selects the stretched period
  assert_len0_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_len == '0) |-> !sel);
endmodule

// File: rtl/fd_period_cnt.sv
module fd_period_cnt
  import frac_div_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] act_div,
  input  logic             sel,
  output logic             strobe
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0]   cnt;
  logic [ARITH_W-1:0] plen;
  logic [CNT_W-1:0]   last_cnt;

  assign plen     = period_len(ARITH_W'(act_div), sel);
  assign last_cnt = CNT_W'(plen - 1);
  assign strobe   = rst_n && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_comb begin
    // R6: the clamped divisor is never below two
    assert_div_floor_R6: assert (eff_div(ARITH_W'(act_div)) >= 2);
  end

  // R2: the counter never runs past the period end
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt);
  // R8: a strobe is always followed by a low cycle
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W   = 7,
  parameter int LEN_W   = 3,
  parameter int DEF_DIV = 8,
  parameter int DEF_LEN = 0,
  parameter int DEF_PAT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [DIV_W-1:0]    cfg_int_div,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [(1<<LEN_W)-1:0] cfg_pattern,
  output logic                div_strobe
);
  localparam int PAT_W = 1 << LEN_W;

  logic [DIV_W-1:0] act_div;
  logic [LEN_W-1:0] act_len;
  logic [PAT_W-1:0] act_pat;
  logic [LEN_W-1:0] stg_len;
  logic             sel;
  logic             cycle_end;
  logic             strobe;

  fd_cfg_stage #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .PAT_W(PAT_W),
    .DEF_DIV(DEF_DIV), .DEF_LEN(DEF_LEN), .DEF_PAT(DEF_PAT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .wr_div(cfg_int_div), .wr_len(cfg_len), .wr_pat(cfg_pattern),
    .cycle_end(cycle_end),
    .act_div(act_div), .act_len(act_len), .act_pat(act_pat), .stg_len(stg_len)
  );

  fd_seq_ptr #(.LEN_W(LEN_W), .PAT_W(PAT_W), .DEF_LEN(DEF_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .act_len(act_len), .act_pat(act_pat), .stg_len(stg_len),
    .sel(sel), .cycle_end(cycle_end)
  );

  fd_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act_div(act_div), .sel(sel), .strobe(strobe)
  );

  assign div_strobe = strobe;

  // R1: no strobe while reset is held
  assert_quiet_reset_R1: assert property (@(posedge clk) !rst_n |-> !div_strobe);
endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_int_div = '0;
  logic [2:0] cfg_len = '0;
  logic [7:0] cfg_pattern = '0;
  logic       div_strobe;

  always #2 clk = ~clk;  // 250 MHz

  frac_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_int_div(cfg_int_div),
    .cfg_len(cfg_len), .cfg_pattern(cfg_pattern), .div_strobe(div_strobe)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R1";

  // Behavioural model: a queue holding the period lengths left in the current replay
  int per_q[$];
  int elapsed = 0;
  int a_div = 8, a_len = 0, a_pat = 0;
  int s_div = 8, s_len = 0, s_pat = 0;
  int iv_log[$];
  int cyc = 0, last_st = 0;

  function automatic int clamp2(int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic refill();
    for (int i = a_len; i >= 0; i--)
      per_q.push_back(clamp2(a_div) + ((a_len != 0 && a_pat[i]) ? 1 : 0));
  endtask

  function automatic bit model_strobe();
    if (!rst_n || per_q.size() == 0) return 1'b0;
    return (elapsed == per_q[0] - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      a_div = 8; a_len = 0; a_pat = 0;
      s_div = 8; s_len = 0; s_pat = 0;
      per_q.delete(); elapsed = 0; refill();
    end else begin
      if (model_strobe()) begin
        void'(per_q.pop_front());
        elapsed = 0;
        if (per_q.size() == 0) begin
          a_div = s_div; a_len = s_len; a_pat = s_pat;
          refill();
        end
      end else elapsed++;
      if (cfg_we) begin
        s_div = cfg_int_div; s_len = cfg_len; s_pat = cfg_pattern;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_vec++;
      if (div_strobe !== model_strobe()) begin
        n_bad++;
        $display("FAIL %s cycle %0d: div_strobe=%0b expected %0b", phase, cyc,
                 div_strobe, model_strobe());
      end
      if (div_strobe === 1'b1) begin
        iv_log.push_back(cyc - last_st);
        last_st = cyc;
      end
    end
  end

  task automatic check(string req, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_cfg(int d, int l, int p);
    @(negedge clk);
    cfg_int_div = 7'(d); cfg_len = 3'(l); cfg_pattern = 8'(p); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    int n20, first20, prev20;
    // R1: reset state and first period with default divisor 8
    run(5);
    check("R1 strobe in reset", int'(div_strobe), 0);
    @(negedge clk) rst_n = 1'b1;
    last_st = cyc;
    run(30);
    check("R1 first default interval", iv_log.size() > 0 ? iv_log[0] : -1, 8);

    // R9: 96/5 example; R7 write applies only after the running cycle
    phase = "R9";
    write_cfg(19, 4, 8'h01);
    run(300);
    iv_log.delete();
    run(200);
    n20 = 0; first20 = -1; prev20 = -1;
    foreach (iv_log[i]) begin
      if (iv_log[i] == 20) begin
        n20++;
        if (prev20 >= 0) check("R9 spacing of 20s", i - prev20, 5);
        prev20 = i;
      end else check("R9 short period", iv_log[i], 19);
    end
    check("R9 some stretched periods", int'(n20 >= 1), 1);

    // R3/R4: full-length pattern
    phase = "R4";
    write_cfg(5, 7, 8'hA5);
    run(400);
    phase = "R3";
    write_cfg(3, 2, 8'h06);
    run(200);

    // R5: length 0 ignores an all-ones pattern
    phase = "R5";
    write_cfg(6, 0, 8'hFF);
    run(100);
    iv_log.delete();
    run(60);
    foreach (iv_log[i]) check("R5 fixed period", iv_log[i], 6);

    // R6: divisor 0 and 1 clamp to 2
    phase = "R6";
    write_cfg(0, 0, 0);
    run(40);
    iv_log.delete();
    run(20);
    foreach (iv_log[i]) check("R6 clamp div0", iv_log[i], 2);
    write_cfg(1, 1, 8'h01);
    run(60);

    // R7: back-to-back and mid-cycle writes
    phase = "R7";
    write_cfg(9, 3, 8'h0C);
    write_cfg(4, 5, 8'h2B);
    run(7);
    write_cfg(11, 6, 8'h55);
    run(500);

    // R2/R8: widest periods
    phase = "R2";
    write_cfg(127, 7, 8'hFF);
    run(2200);
    phase = "R8";
    write_cfg(2, 7, 8'h00);
    run(100);

    // R1: reset in the middle of a run restarts the sequence
    phase = "R1";
    write_cfg(7, 3, 8'h09);
    run(53);
    @(negedge clk) rst_n = 1'b0;
    run(3);
    check("R1 strobe in mid-run reset", int'(div_strobe), 0);
    @(negedge clk) rst_n = 1'b1;
    run(100);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule